// File: doc/BRIEF.md
# Peripheral-Side Single-Address DMA Handshake Engine

This block sits between a double-buffered bulk endpoint store and an external DMA controller that runs in single-address mode. It raises a request when the current buffer half is ready, meaning it holds data when the controller reads or has room when the controller writes. It accepts one byte on each acknowledged strobe and reports every accepted byte with its index and buffer half, so that the neighbouring data path can move it. A transfer on a half ends when the half's byte count is used up or when the controller signals end-of-transfer during an acknowledged strobe. At that point the half is handed back with a one-cycle done pulse and a status pulse.

A one-byte configuration register is loaded through a command/data write port. It holds enable, direction, burst versus single-cycle handshaking, auto-reload, an interrupt pin mode bit and two endpoint interrupt enables. With auto-reload set, the engine moves on to the other buffer half by itself. Without auto-reload it clears its own enable once a transfer ends. In single-cycle mode the request stays low after each byte until acknowledge has been released and a programmable number of idle cycles has passed.

Top module: `sadma_engine`

## Requirements
- R1: After reset the request is low, the configuration reads 0x00, no byte, done or end pulse is emitted, and the current half is half 0.
- R2: A configuration write loads only when the command code is 0xFB; writes with any other code are ignored. Bit positions: 0 enable, 1 direction, 2 burst, 3 auto-reload, 4 interrupt pin mode, 5 and 6 interrupt enables, 7 always reads 0.
- R3: With enable set, the request rises once the ready bit of the current half is 1. While that bit is 0 the request stays low.
- R4: A byte is taken only in a cycle where the request is high and acknowledge and the direction's strobe are both low, and only in the first cycle of that condition. Direction 1 uses the write strobe and direction 0 uses the read strobe; the other strobe is ignored. The cycle after a take, `xfer_o` pulses with `idx_o` (0 for the first byte of a half) and `half_o`.
- R5: In single-cycle mode the request is low in the cycle after a take. Counting from the first clock edge that samples acknowledge high, it rises again after gap_i further edges.
- R6: In burst mode the request stays high across consecutive takes until the transfer ends.
- R7: After the byte that uses up the latched length of the half, `done_o[half]` and `end_o` pulse together for one cycle, and the current half toggles.
- R8: End-of-transfer counts only when it is low in the take cycle. It then ends the transfer after that byte with `end_eot_o` high. When it is low at any other time it has no effect.
- R9: With auto-reload set the enable stays set and the next transfer runs on the other half once that half is ready. Without auto-reload the enable bit reads 0 after the transfer ends.
- R10: Clearing enable drops the request in the cycle after the write and produces no done pulse. On re-enable the same half restarts from byte index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_cmd_i | input | 8 | Command code of the write |
| cfg_data_i | input | 8 | Configuration byte |
| cfg_o | output | 8 | Current configuration |
| gap_i | input | GAP_W | Idle cycles before request re-asserts in single-cycle mode |
| ready_i | input | 2 | Per-half ready flag |
| len_i | input | 2*LW | Per-half byte count, half 0 in the low bits |
| dreq_o | output | 1 | DMA request |
| dack_ni | input | 1 | DMA acknowledge, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| eot_ni | input | 1 | End-of-transfer, active low |
| xfer_o | output | 1 | Byte taken pulse |
| idx_o | output | LW | Index of taken byte in its half |
| half_o | output | 1 | Half of taken byte |
| done_o | output | 2 | Per-half release pulse |
| end_o | output | 1 | Transfer end pulse |
| end_eot_o | output | 1 | Transfer end was caused by end-of-transfer |

## Verification
The hardest situation to reach is a stray end-of-transfer or wrong-direction strobe while a request is pending. Neither may take a byte or end the transfer. The bench reaches it by holding the request high and driving acknowledge with the opposite strobe and end-of-transfer low. It then drives the correct strobe with acknowledge released, and only after that lets a qualified end-of-transfer cut a three-byte half short after its first byte. The back-to-back hand-over between halves under auto-reload is also checked, followed by an idle request once both halves are drained.

// File: rtl/sadma_pkg.sv
package sadma_pkg;
  localparam logic [7:0] CMD_DMA_CFG = 8'hFB;

  typedef struct packed {
    logic rsvd;
    logic ie_b;
    logic ie_a;
    logic int_mode;
    logic reload;
    logic burst;
    logic dir;
    logic en;
  } cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_REL,
    ST_GAP
  } st_e;
endpackage

// File: rtl/sadma_cfg_reg.sv
module sadma_cfg_reg
  import sadma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] cmd_i,
  input  logic [7:0] data_i,
  input  logic       auto_clr_i,
  output cfg_t       cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o <= '0;
    end else if (we_i && cmd_i == CMD_DMA_CFG) begin
      cfg_o <= cfg_t'({1'b0, data_i[6:0]});
    end else if (auto_clr_i) begin
      cfg_o.en <= 1'b0;
    end
  end
endmodule

// File: rtl/sadma_strobe_qual.sv
module sadma_strobe_qual (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dir_i,
  input  logic dack_ni,
  input  logic rd_ni,
  input  logic wr_ni,
  input  logic eot_ni,
  output logic take_o,
  output logic eot_o
);
  logic act, act_q;

  assign act = ~dack_ni & (dir_i ? ~wr_ni : ~rd_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= act;
  end

  // only the onset of a strobe counts as a byte
  assign take_o = act & ~act_q;
  assign eot_o  = act & ~eot_ni;
endmodule

// File: rtl/sadma_fsm.sv
module sadma_fsm
  import sadma_pkg::*;
#(
  parameter int LW    = 7,
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             burst_i,
  input  logic             reload_i,
  input  logic [1:0]       ready_i,
  input  logic [2*LW-1:0]  len_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic             take_i,
  input  logic             eot_i,
  input  logic             dack_ni,
  output logic             dreq_o,
  output logic             auto_clr_o,
  output logic             xfer_o,
  output logic [LW-1:0]    idx_o,
  output logic             half_o,
  output logic [1:0]       done_o,
  output logic             end_o,
  output logic             end_eot_o
);
  st_e              st;
  logic             cur, fin;
  logic [LW-1:0]    cnt, len_q;
  logic [GAP_W-1:0] gcnt;
  logic             acc, last;

  assign dreq_o     = (st == ST_REQ) & en_i;
  assign acc        = dreq_o & take_i;
  assign last       = acc & ((cnt + LW'(1) == len_q) | eot_i);
  assign auto_clr_o = last & ~reload_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= ST_IDLE;
      cur       <= 1'b0;
      fin       <= 1'b0;
      cnt       <= '0;
      len_q     <= '0;
      gcnt      <= '0;
      xfer_o    <= 1'b0;
      idx_o     <= '0;
      half_o    <= 1'b0;
      done_o    <= '0;
      end_o     <= 1'b0;
      end_eot_o <= 1'b0;
    end else begin
      xfer_o    <= 1'b0;
      done_o    <= '0;
      end_o     <= 1'b0;
      end_eot_o <= 1'b0;
      if (!en_i) begin
        st <= ST_IDLE;  // abandon, buffer flags untouched
      end else begin
        unique case (st)
          ST_IDLE: if (ready_i[cur]) begin
            len_q <= len_i[cur*LW +: LW];
            cnt   <= '0;
            st    <= ST_REQ;
          end
          ST_REQ: if (acc) begin
            xfer_o <= 1'b1;
            idx_o  <= cnt;
            half_o <= cur;
            cnt    <= cnt + LW'(1);
            if (last) begin
              done_o[cur] <= 1'b1;
              end_o       <= 1'b1;
              end_eot_o   <= eot_i;
              cur         <= ~cur;
              fin         <= 1'b1;
              st          <= ST_REL;
            end else if (!burst_i) begin
              fin <= 1'b0;
              st  <= ST_REL;
            end
          end
          ST_REL: if (dack_ni) begin
            if (fin)              st <= ST_IDLE;
            else if (gap_i == '0) st <= ST_REQ;
            else begin
              gcnt <= GAP_W'(1);
              st   <= ST_GAP;
            end
          end
          ST_GAP: begin
            if (gcnt >= gap_i) st <= ST_REQ;
            else               gcnt <= gcnt + GAP_W'(1);
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sadma_engine.sv
module sadma_engine
  import sadma_pkg::*;
#(
  parameter int MAX_LEN = 64,
  parameter int GAP_W   = 4,
  localparam int LW     = $clog2(MAX_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [7:0]       cfg_cmd_i,
  input  logic [7:0]       cfg_data_i,
  output logic [7:0]       cfg_o,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [1:0]       ready_i,
  input  logic [2*LW-1:0]  len_i,
  output logic             dreq_o,
  input  logic             dack_ni,
  input  logic             rd_ni,
  input  logic             wr_ni,
  input  logic             eot_ni,
  output logic             xfer_o,
  output logic [LW-1:0]    idx_o,
  output logic             half_o,
  output logic [1:0]       done_o,
  output logic             end_o,
  output logic             end_eot_o
);
  cfg_t cfg;
  logic auto_clr, take, eot_q;

  assign cfg_o = cfg;

  sadma_cfg_reg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .cmd_i      (cfg_cmd_i),
    .data_i     (cfg_data_i),
    .auto_clr_i (auto_clr),
    .cfg_o      (cfg)
  );

  sadma_strobe_qual u_qual (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_i   (cfg.dir),
    .dack_ni (dack_ni),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .eot_ni  (eot_ni),
    .take_o  (take),
    .eot_o   (eot_q)
  );

  sadma_fsm #(.LW(LW), .GAP_W(GAP_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (cfg.en),
    .burst_i    (cfg.burst),
    .reload_i   (cfg.reload),
    .ready_i    (ready_i),
    .len_i      (len_i),
    .gap_i      (gap_i),
    .take_i     (take),
    .eot_i      (eot_q),
    .dack_ni    (dack_ni),
    .dreq_o     (dreq_o),
    .auto_clr_o (auto_clr),
    .xfer_o     (xfer_o),
    .idx_o      (idx_o),
    .half_o     (half_o),
    .done_o     (done_o),
    .end_o      (end_o),
    .end_eot_o  (end_eot_o)
  );
endmodule

// File: rtl/sadma_engine_chk.sv
module sadma_engine_chk #(
  parameter int LW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    cfg_o,
  input logic          dreq_o,
  input logic          xfer_o,
  input logic [1:0]    done_o,
  input logic          end_o,
  input logic          end_eot_o
);
  AST_END_HAS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> ($countones(done_o) == 1)); // R7
  AST_EOT_IMPLIES_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_eot_o |-> end_o); // R8
  AST_XFER_WHILE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> $past(dreq_o)); // R4
  AST_SINGLE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !$past(cfg_o[2])) |-> !dreq_o); // R5
  AST_BURST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !end_o && $past(cfg_o[2]) && cfg_o[2] && cfg_o[0]) |-> dreq_o); // R6
endmodule

bind sadma_engine sadma_engine_chk #(.LW(LW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_o     (cfg_o),
  .dreq_o    (dreq_o),
  .xfer_o    (xfer_o),
  .done_o    (done_o),
  .end_o     (end_o),
  .end_eot_o (end_eot_o)
);

// File: tb/sadma_engine_test.sv
`timescale 1ns/1ps
module sadma_engine_test;
  localparam int MAX_LEN = 64;
  localparam int GAP_W   = 4;
  localparam int LW      = $clog2(MAX_LEN + 1);

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic             we;
  logic [7:0]       cmd, wdata, cfg;
  logic [GAP_W-1:0] gap;
  logic [1:0]       ready;
  logic [2*LW-1:0]  len;
  logic             dreq, dack_n, rd_n, wr_n, eot_n;
  logic             xfer, half, end_p, end_eot;
  logic [LW-1:0]    idx;
  logic [1:0]       done;

  sadma_engine #(.MAX_LEN(MAX_LEN), .GAP_W(GAP_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_cmd_i(cmd), .cfg_data_i(wdata),
    .cfg_o(cfg), .gap_i(gap), .ready_i(ready), .len_i(len), .dreq_o(dreq),
    .dack_ni(dack_n), .rd_ni(rd_n), .wr_ni(wr_n), .eot_ni(eot_n), .xfer_o(xfer),
    .idx_o(idx), .half_o(half), .done_o(done), .end_o(end_p), .end_eot_o(end_eot)
  );

  int n_chk = 0, n_bad = 0;
  int exp_half = 0;
  bit cur_dir = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk); we = 1'b1; cmd = c; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_req(input string req);
    int n = 0;
    while (!dreq && n < 20) begin @(negedge clk); n++; end
    chk(req, "request rises", dreq, 1);
  endtask

  task automatic do_byte(input int k, input int ln, input bit eot, input bit burst,
                         input int g, input bit reload, output bit ended);
    bit last;
    int n;
    dack_n = 1'b0; if (cur_dir) wr_n = 1'b0; else rd_n = 1'b0; eot_n = ~eot;
    @(negedge clk);
    last = eot || (k == ln - 1);
    chk("R4", "xfer", xfer, 1);
    chk("R4", "idx", int'(idx), k);
    chk("R4", "half", half, exp_half);
    chk("R7", "end", end_p, last);
    chk("R8", "end_eot", end_eot, last && eot);
    chk("R7", "done", done, last ? (1 << exp_half) : 0);
    if (last) chk("R9", "enable after end", cfg[0], reload);
    if (burst && !last) chk("R6", "request held", dreq, 1);
    else                chk("R5", "request dropped", dreq, 0);
    rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
    ended = last;
    if (!burst || last) dack_n = 1'b1;
    if (last) begin
      ready[exp_half] = 1'b0;
      exp_half ^= 1;
      repeat (2) @(negedge clk);
    end else if (!burst) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!dreq && n < 40);
      chk("R5", "gap cycles", n, g + 1);
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic run_xfer(input bit d, input bit burst, input int ln, input int g);
    bit ended = 0;
    cur_dir = d;
    len[exp_half*LW +: LW] = LW'(ln);
    ready[exp_half] = 1'b1;
    gap = GAP_W'(g);
    cfg_wr(8'hFB, {4'b0, 1'b0, burst, d, 1'b1});
    wait_req("R3");
    for (int k = 0; k < ln && !ended; k++) do_byte(k, ln, 1'b0, burst, g, 1'b0, ended);
  endtask

  initial begin
    bit ended;
    rst_n = 1'b0; we = 1'b0; cmd = '0; wdata = '0; gap = '0; ready = '0; len = '0;
    dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; eot_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "dreq", dreq, 0); chk("R1", "cfg", cfg, 0); chk("R1", "xfer", xfer, 0);
    chk("R1", "done", done, 0); chk("R1", "end", end_p, 0);
    rst_n = 1'b1;
    @(negedge clk);

    cfg_wr(8'hFA, 8'hFF);
    chk("R2", "wrong code ignored", cfg, 0);
    cfg_wr(8'hFB, 8'hE0);
    chk("R2", "bit 7 reads zero", cfg, 8'h60);
    cfg_wr(8'hFB, 8'h5A);
    chk("R2", "field layout", cfg, 8'h5A);
    cfg_wr(8'hFB, 8'h00);

    cfg_wr(8'hFB, 8'h01);
    repeat (5) @(negedge clk);
    chk("R3", "no request while half not ready", dreq, 0);
    cfg_wr(8'hFB, 8'h00);

    for (int d = 0; d < 2; d++)
      for (int b = 0; b < 2; b++)
        for (int ln = 1; ln <= 4; ln++)
          for (int g = 0; g <= (b ? 0 : 2); g++)
            run_xfer(d[0], b[0], ln, g);

    // stray strobes and unqualified end-of-transfer, then a qualified one
    cur_dir = 1'b0; gap = '0;
    len[exp_half*LW +: LW] = LW'(3); ready[exp_half] = 1'b1;
    cfg_wr(8'hFB, 8'h01);
    wait_req("R3");
    dack_n = 1'b0; wr_n = 1'b0; eot_n = 1'b0;
    @(negedge clk);
    dack_n = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
    chk("R4", "wrong strobe ignored", xfer, 0);
    chk("R8", "stray eot ignored", end_p, 0);
    @(negedge clk);
    rd_n = 1'b1; eot_n = 1'b1;
    chk("R4", "no take without ack", xfer, 0);
    chk("R8", "eot without ack ignored", end_p, 0);
    chk("R4", "request still pending", dreq, 1);
    @(negedge clk);
    do_byte(0, 3, 1'b1, 1'b0, 0, 1'b0, ended);
    chk("R8", "eot ended early", ended, 1);

    // disable abandons, re-enable restarts same half
    cur_dir = 1'b1;
    len[exp_half*LW +: LW] = LW'(3); ready[exp_half] = 1'b1;
    cfg_wr(8'hFB, 8'h03);
    wait_req("R3");
    do_byte(0, 3, 1'b0, 1'b0, 0, 1'b0, ended);
    @(negedge clk); we = 1'b1; cmd = 8'hFB; wdata = 8'h02;
    @(negedge clk); we = 1'b0;
    chk("R10", "request dropped on disable", dreq, 0);
    chk("R10", "no done on disable", done, 0);
    repeat (3) @(negedge clk);
    chk("R10", "no done later", done, 0);
    cfg_wr(8'hFB, 8'h03);
    wait_req("R10");
    ended = 0;
    for (int k = 0; k < 3 && !ended; k++) do_byte(k, 3, 1'b0, 1'b0, 0, 1'b0, ended);

    // auto-reload across both halves
    cur_dir = 1'b0; gap = '0;
    len[exp_half*LW +: LW] = LW'(2);
    len[(exp_half ^ 1)*LW +: LW] = LW'(3);
    ready = 2'b11;
    cfg_wr(8'hFB, 8'h09);
    wait_req("R3");
    ended = 0;
    for (int k = 0; k < 2 && !ended; k++) do_byte(k, 2, 1'b0, 1'b0, 0, 1'b1, ended);
    chk("R9", "enable kept", cfg[0], 1);
    wait_req("R9");
    ended = 0;
    for (int k = 0; k < 3 && !ended; k++) do_byte(k, 3, 1'b0, 1'b0, 0, 1'b1, ended);
    repeat (6) @(negedge clk);
    chk("R9", "idle with both halves drained", dreq, 0);
    chk("R9", "enable still set", cfg[0], 1);
    cfg_wr(8'hFB, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule